// File: doc/BRIEF.md
# Operator Envelope Generator (ADSR with Rate Scaling)

This block shapes the loudness of one synthesis operator over time. It tracks a 10-bit attenuation, where 0 is full volume and 0x3FF is silence, through four named states: ST_ATTACK, ST_DECAY, ST_SUSTAIN and ST_RELEASE. A host drives a one-cycle `sample_en` strobe once per audio sample, together with the key input and the per-operator rate settings. On every third strobe an internal envelope timer ticks, and only on a tick can the level move. The size of each move is computed from an effective rate that folds in key scaling. The timer's trailing-zero position or its two low bits then pick the step.

The transitions are as follows:
- Key-on edge: any state goes to ST_ATTACK.
- Attack complete: ST_ATTACK goes to ST_DECAY when the level is 0.
- Sustain reached: ST_DECAY goes to ST_SUSTAIN when the level matches the sustain target.
- Key release: any state goes to ST_RELEASE while the key is low.
- Silence clamp: any state except ST_ATTACK goes to ST_RELEASE at 0x3FF once the level is nearly silent.

The output adds the total level and an amplitude-modulation offset to the envelope and saturates the sum.

Top module: `adsr_env`

## Requirements
- R1: After reset the state is ST_RELEASE, the level is 0x3FF and `atten_o` reads 0x3FF.
- R2: The key and all settings are acted on only in cycles with `sample_en` high. A strobe with `key_on` high after a strobe with it low (or after reset) enters ST_ATTACK. A strobe with `key_on` low selects ST_RELEASE.
- R3: The envelope timer is a 12-bit counter that increments on every third strobe (the 3rd, 6th, ... after reset); those strobes are ticks. The timer shift is 0 when the counter is 0, otherwise the index of its lowest set bit plus one. The step is 0 on non-tick strobes and whenever the selected 5-bit rate is 0.
- R4: The selected rate is the attack rate on a key-on edge or in ST_ATTACK, the decay rate in ST_DECAY, the sustain rate in ST_SUSTAIN, and (release<<1)|1 in ST_RELEASE. The effective rate is min(2*selected + ksv, 63). Here ksv = keycode >> (ks XOR 3), and it is registered at each strobe and used from the next strobe on.
- R5: For effective rates below 48, let s = ((rate>>2) + shift) mod 16. The step is 1 when s=12, rate bit 1 when s=13, rate bit 0 when s=14, and 0 otherwise.
- R6: For effective rates of 48 or more, the step is min(row + (rate>>2) - 11, 4). The row bit is indexed by rate[1:0] and the timer's two low bits t: 0 for rate[1:0]=0; (t==0) for 1; (t is even) for 2; (t!=3) for 3.
- R7: In ST_ATTACK with a nonzero step and an effective rate below 62, the level becomes level - ceil((level+1)*2^step/32). A key-on edge with effective rate 62 or 63 zeroes the level at once. Otherwise a key-on edge leaves the level unchanged. ST_ATTACK with level 0 moves to ST_DECAY.
- R8: In ST_DECAY, ST_SUSTAIN and ST_RELEASE a nonzero step adds 2^(step-1). ST_DECAY moves to ST_SUSTAIN when level>>4 equals twice the sustain target; the target is 31 for a 4-bit sustain code of 15 and the code itself otherwise.
- R9: Outside ST_ATTACK, and with no key-on edge, a level with bits [9:4] all ones forces ST_RELEASE and level 0x3FF.
- R10: `atten_o` equals min(level + 8*total_level + am, 0x3FF), registered one clock after the level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | One-cycle strobe per audio sample |
| key_on | input | 1 | Key held (1) or released (0) |
| atk_rate | input | 5 | Attack rate |
| dec_rate | input | 5 | Decay rate |
| sus_rate | input | 5 | Sustain-phase rate |
| rel_rate | input | 4 | Release rate |
| sus_lvl | input | 4 | Sustain target code |
| key_scale | input | 2 | Key-scaling depth |
| key_code | input | 5 | Pitch key code |
| total_lvl | input | 7 | Static attenuation, in steps of 8 |
| am_ofs | input | 7 | Amplitude-modulation offset |
| atten_o | output | 10 | Saturated attenuation |

## Verification
A strobe raised before clock edge A changes the state and level at edge A. `atten_o` shows the result at edge B, the following edge, so each result is due two rising edges after the strobe is raised. The driver records the current cycle number with every expected value it queues. The monitor pops an entry only when its own cycle counter reaches that number plus two, and it samples 2 ns after that edge. Strobes are spaced three cycles apart, so a result is always checked before the next strobe changes the level.

// File: rtl/adsr_pkg.sv
package adsr_pkg;
    typedef enum logic [1:0] {
        ST_ATTACK  = 2'd0,
        ST_DECAY   = 2'd1,
        ST_SUSTAIN = 2'd2,
        ST_RELEASE = 2'd3
    } env_state_t;
endpackage

// File: rtl/adsr_timer.sv
module adsr_timer #(
    parameter int TMR_W = 12,
    parameter int DIV   = 3,
    parameter int SHW   = $clog2(TMR_W + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sample_en,
    output logic           tick_o,
    output logic [SHW-1:0] shift_o,
    output logic [1:0]     low2_o
);
    localparam int DIV_W = $clog2(DIV);

    logic [DIV_W-1:0] div_q;
    logic [TMR_W-1:0] tmr_q;

    assign tick_o = sample_en && (div_q == DIV_W'(DIV - 1));
    assign low2_o = tmr_q[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            tmr_q <= '0;
        end else if (sample_en) begin
            div_q <= tick_o ? '0 : div_q + 1'b1;
            if (tick_o) tmr_q <= tmr_q + 1'b1;
        end
    end

    // lowest set bit position plus one, 0 for an all-zero counter
    always_comb begin
        shift_o = '0;
        for (int i = TMR_W - 1; i >= 0; i--) begin
            if (tmr_q[i]) shift_o = SHW'(i + 1);
        end
    end

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/adsr_step.sv
module adsr_step #(
    parameter int RATE_W = 5,
    parameter int SHW    = 4
) (
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [RATE_W-1:0] ksv_i,
    input  logic [SHW-1:0]    shift_i,
    input  logic [1:0]        low2_i,
    output logic [2:0]        step_o,
    output logic              ratemax_o
);
    localparam int EW = RATE_W + 2;

    logic [EW-1:0] raw;
    logic [5:0]    eff;
    logic [3:0]    quarter;
    logic [3:0]    phase_sum;
    logic          row_bit;
    logic [4:0]    hi_step;
    logic [2:0]    lo_step;

    always_comb begin
        raw       = EW'({rate_i, 1'b0}) + EW'(ksv_i);
        eff       = (raw > EW'(63)) ? 6'd63 : raw[5:0];
        quarter   = eff[5:2];
        phase_sum = 4'(32'(quarter) + 32'(shift_i));
        unique case (eff[1:0])
            2'd0: row_bit = 1'b0;
            2'd1: row_bit = (low2_i == 2'd0);
            2'd2: row_bit = !low2_i[0];
            2'd3: row_bit = (low2_i != 2'd3);
        endcase
        hi_step = 5'(row_bit) + 5'(quarter) - 5'd11;
        unique case (phase_sum)
            4'd12:   lo_step = 3'd1;
            4'd13:   lo_step = {2'b0, eff[1]};
            4'd14:   lo_step = {2'b0, eff[0]};
            default: lo_step = 3'd0;
        endcase
        if (!tick_i || rate_i == '0)  step_o = 3'd0;
        else if (eff < 6'd48)          step_o = lo_step;
        else if (hi_step > 5'd4)       step_o = 3'd4;
        else                           step_o = hi_step[2:0];
        ratemax_o = (eff[5:1] == 5'h1F);
    end
endmodule

// File: rtl/adsr_outsat.sv
module adsr_outsat #(
    parameter int LVL_W = 10,
    parameter int TL_W  = 7,
    parameter int AM_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    input  logic [TL_W-1:0]  tl_i,
    input  logic [AM_W-1:0]  am_i,
    output logic [LVL_W-1:0] atten_o
);
    localparam int SW = LVL_W + 3;

    logic [SW-1:0] total;

    assign total = SW'(level_i) + (SW'(tl_i) << 3) + SW'(am_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) atten_o <= '1;
        else        atten_o <= (total > SW'({LVL_W{1'b1}})) ? '1 : total[LVL_W-1:0];
    end
endmodule

// File: rtl/adsr_env.sv
module adsr_env
    import adsr_pkg::*;
#(
    parameter int LVL_W  = 10,
    parameter int RATE_W = 5,
    parameter int RR_W   = 4,
    parameter int SL_W   = 4,
    parameter int TL_W   = 7,
    parameter int AM_W   = 7,
    parameter int TMR_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_en,
    input  logic              key_on,
    input  logic [RATE_W-1:0] atk_rate,
    input  logic [RATE_W-1:0] dec_rate,
    input  logic [RATE_W-1:0] sus_rate,
    input  logic [RR_W-1:0]   rel_rate,
    input  logic [SL_W-1:0]   sus_lvl,
    input  logic [1:0]        key_scale,
    input  logic [RATE_W-1:0] key_code,
    input  logic [TL_W-1:0]   total_lvl,
    input  logic [AM_W-1:0]   am_ofs,
    output logic [LVL_W-1:0]  atten_o
);
    localparam int SHW = $clog2(TMR_W + 1);
    localparam int AW  = LVL_W + 6;
    localparam int SLX = SL_W + 1;

    env_state_t        state_q, nxt_state;
    logic [LVL_W-1:0]  level_q, nxt_level;
    logic              kon_q;
    logic [RATE_W-1:0] ksv_q;

    logic              tick;
    logic [SHW-1:0]    shift;
    logic [1:0]        low2;
    logic [2:0]        step;
    logic              ratemax;
    logic              rising;
    logic              near_silent;
    logic [RATE_W-1:0] rate_sel;
    logic [SLX-1:0]    sl_exp;
    logic [AW-1:0]     base, inc;
    logic signed [AW-1:0] lv_s, neg_s, sh_s, atk_s;

    adsr_timer #(.TMR_W(TMR_W), .DIV(3), .SHW(SHW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .tick_o    (tick),
        .shift_o   (shift),
        .low2_o    (low2)
    );

    adsr_step #(.RATE_W(RATE_W), .SHW(SHW)) u_step (
        .tick_i    (tick),
        .rate_i    (rate_sel),
        .ksv_i     (ksv_q),
        .shift_i   (shift),
        .low2_i    (low2),
        .step_o    (step),
        .ratemax_o (ratemax)
    );

    adsr_outsat #(.LVL_W(LVL_W), .TL_W(TL_W), .AM_W(AM_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (level_q),
        .tl_i    (total_lvl),
        .am_i    (am_ofs),
        .atten_o (atten_o)
    );

    assign rising      = key_on && !kon_q;
    assign near_silent = &level_q[LVL_W-1:4];
    assign sl_exp      = (&sus_lvl) ? '1 : SLX'(sus_lvl);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RELEASE;
            level_q <= '1;
            kon_q   <= 1'b0;
            ksv_q   <= '0;
        end else if (sample_en) begin
            state_q <= nxt_state;
            level_q <= nxt_level;
            kon_q   <= key_on;
            ksv_q   <= key_code >> (key_scale ^ 2'b11);
        end
    end

    // rate selection, increments and transitions
    always_comb begin
        if (rising) rate_sel = atk_rate;
        else begin
            unique case (state_q)
                ST_ATTACK:  rate_sel = atk_rate;
                ST_DECAY:   rate_sel = dec_rate;
                ST_SUSTAIN: rate_sel = sus_rate;
                ST_RELEASE: rate_sel = RATE_W'({rel_rate, 1'b1});
            endcase
        end

        lv_s  = signed'(AW'(level_q));
        neg_s = ~lv_s;
        sh_s  = neg_s <<< step;
        atk_s = sh_s >>> 5;

        nxt_state = state_q;
        base      = AW'(level_q);
        inc       = '0;
        if (rising) begin
            nxt_state = ST_ATTACK;
            if (ratemax) base = '0;
        end else begin
            unique case (state_q)
                ST_ATTACK: begin
                    if (level_q == '0)                 nxt_state = ST_DECAY;
                    else if (step != 3'd0 && !ratemax) inc = atk_s;
                end
                ST_DECAY: begin
                    if (level_q[LVL_W-1:4] == (LVL_W-4)'({sl_exp, 1'b0}))
                        nxt_state = ST_SUSTAIN;
                    else if (!near_silent && step != 3'd0)
                        inc = AW'(1) << (step - 3'd1);
                end
                ST_SUSTAIN, ST_RELEASE: begin
                    if (!near_silent && step != 3'd0)
                        inc = AW'(1) << (step - 3'd1);
                end
            endcase
            if (!key_on) nxt_state = ST_RELEASE;
            if (state_q != ST_ATTACK && near_silent) begin
                nxt_state = ST_RELEASE;
                base      = AW'({LVL_W{1'b1}});
            end
        end
        nxt_level = LVL_W'(base + inc);
    end

    // R9
    silence_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !rising && state_q != ST_ATTACK && near_silent)
        |=> (level_q == '1 && state_q == ST_RELEASE));

    // R7
    ratemax_kon_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && rising && ratemax) |=> (level_q == '0 && state_q == ST_ATTACK));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(state_q) && $stable(level_q)));

    // R2
    keyoff_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !key_on) |=> state_q == ST_RELEASE);

    // R3
    step_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step != 3'd0) |-> tick);

    // R8
    level_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && key_on && !rising && state_q != ST_ATTACK)
        |=> level_q >= $past(level_q));

    // R10
    out_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> atten_o >= $past(level_q));
endmodule

// File: tb/sim_adsr_env.sv
module sim_adsr_env;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_en = 1'b0;
    logic       key_on = 1'b0;
    logic [4:0] atk_rate = '0, dec_rate = '0, sus_rate = '0;
    logic [3:0] rel_rate = '0, sus_lvl = '0;
    logic [1:0] key_scale = '0;
    logic [4:0] key_code = '0;
    logic [6:0] total_lvl = '0, am_ofs = '0;
    logic [9:0] atten_o;

    always #5 clk = ~clk;

    adsr_env u0 (
        .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .key_on(key_on),
        .atk_rate(atk_rate), .dec_rate(dec_rate), .sus_rate(sus_rate),
        .rel_rate(rel_rate), .sus_lvl(sus_lvl), .key_scale(key_scale),
        .key_code(key_code), .total_lvl(total_lvl), .am_ofs(am_ofs),
        .atten_o(atten_o)
    );

    typedef struct {
        int    exp_v;
        string tag;
        int    due;
    } item_t;

    item_t sb_q[$];
    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;

    // reference model state
    int m_state = 3, m_level = 1023, m_kon = 0, m_div = 0, m_tmr = 0, m_ksv = 0;
    int rowtab[4][4] = '{'{0,0,0,0}, '{1,0,0,0}, '{1,0,1,0}, '{1,1,1,0}};

    task automatic check(input string tag, input int act, input int exp_v);
        checks++;
        if (act != exp_v) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp_v);
        end
    endtask

    // monitor: compares each queued item two edges after its strobe
    always begin
        @(posedge clk);
        cyc++;
        #2;
        if (sb_q.size() > 0 && sb_q[0].due == cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, int'(atten_o), it.exp_v);
        end
    end

    function automatic int model_sample();
        int rising, rsel, eff, tick, shift, st, s, rmax, slx, off, nl, ns, tot;
        rising = (key_on && !m_kon) ? 1 : 0;
        if (rising != 0) rsel = atk_rate;
        else case (m_state)
            0: rsel = atk_rate;
            1: rsel = dec_rate;
            2: rsel = sus_rate;
            default: rsel = rel_rate * 2 + 1;
        endcase
        eff = 2 * rsel + m_ksv;
        if (eff > 63) eff = 63;
        tick = (m_div == 2) ? 1 : 0;
        shift = 0;
        if (m_tmr != 0) begin
            for (int b = 11; b >= 0; b--) if (((m_tmr >> b) & 1) != 0) shift = b + 1;
        end
        st = 0;
        if (tick != 0 && rsel != 0) begin
            if (eff < 48) begin
                s = ((eff / 4) + shift) % 16;
                if (s == 12) st = 1;
                else if (s == 13) st = (eff / 2) % 2;
                else if (s == 14) st = eff % 2;
            end else begin
                st = rowtab[eff % 4][m_tmr % 4] + eff / 4 - 11;
                if (st > 4) st = 4;
            end
        end
        rmax = (eff >= 62) ? 1 : 0;
        slx = (sus_lvl == 15) ? 31 : int'(sus_lvl);
        off = ((m_level / 16) == 63) ? 1 : 0;
        nl = m_level;
        ns = m_state;
        if (rising != 0) begin
            ns = 0;
            if (rmax != 0) nl = 0;
        end else begin
            case (m_state)
                0: begin
                    if (m_level == 0) ns = 1;
                    else if (st != 0 && rmax == 0)
                        nl = m_level - (((m_level + 1) * (1 << st) + 31) / 32);
                end
                1: begin
                    if ((m_level / 16) == 2 * slx) ns = 2;
                    else if (off == 0 && st != 0) nl = m_level + (1 << (st - 1));
                end
                default: if (off == 0 && st != 0) nl = m_level + (1 << (st - 1));
            endcase
            if (!key_on) ns = 3;
            if (m_state != 0 && off != 0) begin
                ns = 3;
                nl = 1023;
            end
        end
        m_state = ns;
        m_level = nl;
        m_kon = key_on ? 1 : 0;
        m_ksv = int'(key_code) >> (key_scale ^ 2'b11);
        if (tick != 0) begin
            m_div = 0;
            m_tmr = (m_tmr + 1) % 4096;
        end else m_div++;
        tot = nl + 8 * int'(total_lvl) + int'(am_ofs);
        return (tot > 1023) ? 1023 : tot;
    endfunction

    // driver: one strobe, expected value pushed for the monitor
    task automatic do_sample(input string tag);
        item_t it;
        @(negedge clk);
        sample_en = 1'b1;
        it.exp_v = model_sample();
        it.tag = tag;
        it.due = cyc + 2;
        sb_q.push_back(it);
        @(negedge clk);
        sample_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) do_sample(tag);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset attenuation", int'(atten_o), 10'h3FF);

        // strobes with key low from reset: release, stays silent (R2, R3)
        run(4, "R2 idle release");

        // fast key-on, decay by high-rate step (R6), sustain hold (R5)
        atk_rate = 5'd31; dec_rate = 5'd26; sus_rate = 5'd4;
        rel_rate = 4'd15; sus_lvl = 4'd4;
        key_on = 1'b1;
        do_sample("R7 ratemax key-on");
        check("R7 level zeroed", int'(atten_o), 0);
        run(220, "R6 decay high rate");
        run(40, "R5 sustain low rate");
        check("R8 sustain target 0x80", int'(atten_o), 10'h080);

        // release to silence (R4 release expansion, R9 clamp)
        key_on = 1'b0;
        run(360, "R9 release to silence");
        check("R9 silent after release", int'(atten_o), 10'h3FF);

        // key scaling and exponential attack (R4, R7)
        key_scale = 2'd1; key_code = 5'd31;
        atk_rate = 5'd20; dec_rate = 5'd0;
        key_on = 1'b1;
        run(520, "R7 exponential attack");
        run(10, "R3 zero rate holds");
        check("R7 attack reached zero", int'(atten_o), 0);

        // sustain code 15 expands to 31 (R8)
        key_on = 1'b0;
        run(2, "R2 key-off");
        atk_rate = 5'd31; dec_rate = 5'd31; sus_rate = 5'd0; sus_lvl = 4'd15;
        key_on = 1'b1;
        run(420, "R8 decay to expanded target");
        run(30, "R3 sustain rate zero");
        check("R8 expanded sustain 0x3E0", int'(atten_o), 10'h3E0);

        // output sum and saturation (R10)
        total_lvl = 7'd3; am_ofs = 7'd5;
        run(3, "R10 sum");
        total_lvl = 7'd127;
        run(3, "R10 saturate");
        total_lvl = 7'd1; am_ofs = 7'd0;
        run(3, "R10 tl only");

        // retrigger mid-release (R2, R4)
        key_on = 1'b0;
        run(20, "R4 release rate");
        key_on = 1'b1; atk_rate = 5'd18;
        run(60, "R2 retrigger attack");

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule